// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three motor phases. Each phase has a positive (high-side) output and a negative (low-side) output. The two outputs of a phase are never on together, and a guaranteed off gap lies between them. Two triangle carrier counters produce that gap. Counter A runs between the dead-time value and the upper limit. Counter B runs between zero and the upper limit minus the dead time. Both counters step together, so B always trails A by exactly the dead time. A per-phase duty value is compared against both counters, and each output is registered.

Software writes the upper limit, the dead time and the three duty values through a simple write port. The upper limit and the duty values go into buffers first. The active copies are taken from the buffers only at a carrier crest or a carrier trough, so a new setting never shows up part-way through a half cycle. A prescaler lets the counters step once every `DIV` clocks. The `run` input starts and stops the whole timer.

Top module: `cpwm3_top`

## Requirements
- R1: While `rst` is high, and one clock after `run` goes low, all six outputs are 0. A stopped timer reloads counter A with the dead time and counter B with 0.
- R2: While running, both counters change only once every `DIV` clocks (default 4). Every carrier timing is therefore a whole multiple of `DIV` clocks.
- R3: Counter A counts up from the dead time D_T to the upper limit L, then back down to D_T. Counter B always equals A minus D_T. The carrier period is 2*(L-D_T)*DIV clocks.
- R4: For a phase with active duty D, `out_p` is 1 in the clock after a step where B >= D, and `out_n` is 1 in the clock after a step where A < D.
- R5: Within a phase, `out_p` and `out_n` are never both 1. When the duty is unsaturated, the gap from `out_n` falling to `out_p` rising, and from `out_p` falling to `out_n` rising, is exactly D_T*DIV clocks.
- R6: A duty write goes into the buffer only. The buffer is copied to the active duty on the step where A reaches L (crest) or reaches D_T (trough), and continuously while the timer is stopped.
- R7: The upper limit is buffered in the same way. A new limit written during an up-count takes effect only after the next crest.
- R8: Dead-time writes are accepted only while `run` is 0. A dead-time write made while the timer is running is discarded.
- R9: A duty of 0 holds `out_p` at 1 and `out_n` at 0 for the whole carrier. A duty above L holds `out_n` at 1 and `out_p` at 0. In both cases neither output makes a pulse.
- R10: Write select codes are: 0 for the upper limit, 1 for the dead time, and 2, 3, 4 for the duty of phases 0, 1, 2. Writes with any other code change nothing.
- R11: After reset, the settings are L=2040, D_T=40 and a duty of 1020 on every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = timer counting, 0 = stopped with outputs off |
| wr_en | input | 1 | Write strobe for the setting registers |
| wr_sel | input | SEL_W | Register select code (see R10) |
| wr_data | input | W | Write data |
| out_p | output | NPH | Positive output of each phase |
| out_n | output | NPH | Negative output of each phase |

## Verification
The bench writes a duty change and a limit change just after the low-side edge of the up-count. It then times the next high-side pulse against the value that belongs to the old half cycle. A design that copied buffers at once would give a visibly shorter pulse or a longer period. Saturated duties (0, equal to the limit, above the limit) are counted over a whole carrier: a design that mishandled the ends would emit a stray one-step pulse or lose one. The dead gap is timed edge to edge on both transitions, and an ignored dead-time write while running is checked the same way. An off-by-one in the turn-around or the prescaler would shift every measured time.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;
  // write select codes
  localparam int SEL_LIM   = 0;
  localparam int SEL_DEAD  = 1;
  localparam int SEL_DUTY0 = 2;

  typedef enum logic {
    CNT_DN = 1'b0,
    CNT_UP = 1'b1
  } cdir_e;
endpackage

// File: rtl/cpwm3_prescale.sv
module cpwm3_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || !run)              pre <= '0;
        else if (pre == PW'(DIV - 1)) pre <= '0;
        else                          pre <= pre + 1'b1;
      end
      assign tick = run && (pre == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/cpwm3_regs.sv
module cpwm3_regs
  import cpwm3_pkg::*;
#(
  parameter int W        = 16,
  parameter int NPH      = 3,
  parameter int SEL_W    = 3,
  parameter int LIM_RST  = 2040,
  parameter int DEAD_RST = 40,
  parameter int DUTY_RST = 1020
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    load,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            lim_act,
  output logic [W-1:0]            dead_q,
  output logic [W-1:0]            dead_nx,
  output logic [NPH-1:0][W-1:0]   duty_act
);
  logic [W-1:0]          lim_buf, lim_nx;
  logic [NPH-1:0][W-1:0] duty_buf, duty_nx;

  // buffer contents after this cycle's write
  always_comb begin
    lim_nx  = lim_buf;
    duty_nx = duty_buf;
    dead_nx = dead_q;
    if (wr_en) begin
      if (wr_sel == SEL_W'(SEL_LIM)) lim_nx = wr_data;
      if (wr_sel == SEL_W'(SEL_DEAD) && !run) dead_nx = wr_data;
      for (int i = 0; i < NPH; i++) begin
        if (wr_sel == SEL_W'(SEL_DUTY0 + i)) duty_nx[i] = wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_buf  <= W'(LIM_RST);
      lim_act  <= W'(LIM_RST);
      dead_q   <= W'(DEAD_RST);
      duty_buf <= {NPH{W'(DUTY_RST)}};
      duty_act <= {NPH{W'(DUTY_RST)}};
    end else begin
      lim_buf  <= lim_nx;
      duty_buf <= duty_nx;
      dead_q   <= dead_nx;
      if (load) begin
        lim_act  <= lim_nx;
        duty_act <= duty_nx;
      end
    end
  end
endmodule

// File: rtl/cpwm3_carrier.sv
module cpwm3_carrier
  import cpwm3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] dead_ld,
  input  logic [W-1:0] dead,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         up,
  output logic         evt
);
  cdir_e         dir;
  logic [W-1:0]  a_inc, a_dec;
  logic          at_top, at_bot;

  assign a_inc  = cnt_a + 1'b1;
  assign a_dec  = cnt_a - 1'b1;
  assign at_top = (a_inc >= lim);
  assign at_bot = (a_dec <= dead);
  assign up     = (dir == CNT_UP);
  // crest or trough reached on this step
  assign evt    = run && tick && (up ? at_top : at_bot);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_a <= dead_ld;
      cnt_b <= '0;
      dir   <= CNT_UP;
    end else if (tick) begin
      if (dir == CNT_UP) begin
        cnt_a <= a_inc;
        cnt_b <= cnt_b + 1'b1;
        if (at_top) dir <= CNT_DN;
      end else begin
        cnt_a <= a_dec;
        cnt_b <= cnt_b - 1'b1;
        if (at_bot) dir <= CNT_UP;
      end
    end
  end
endmodule

// File: rtl/cpwm3_phase.sv
module cpwm3_phase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] cnt_a,
  input  logic [W-1:0] cnt_b,
  input  logic [W-1:0] duty,
  output logic         out_p,
  output logic         out_n
);
  logic p_on, n_on;

  // high side needs the lagging counter past duty, low side the leading one below
  assign p_on = (cnt_b >= duty);
  assign n_on = (cnt_a <  duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_p <= 1'b0;
      out_n <= 1'b0;
    end else begin
      out_p <= run && p_on;
      out_n <= run && n_on;
    end
  end
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top #(
  parameter int W        = 16,
  parameter int NPH      = 3,
  parameter int DIV      = 4,
  parameter int LIM_RST  = 2040,
  parameter int DEAD_RST = 40,
  parameter int DUTY_RST = 1020,
  parameter int SEL_W    = $clog2(NPH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [NPH-1:0]   out_p,
  output logic [NPH-1:0]   out_n
);
  logic                  tick, up, evt, load;
  logic [W-1:0]          cnt_a, cnt_b, lim_act, dead_q, dead_nx;
  logic [NPH-1:0][W-1:0] duty_act;

  assign load = !run || evt;

  cpwm3_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  cpwm3_regs #(
    .W(W), .NPH(NPH), .SEL_W(SEL_W),
    .LIM_RST(LIM_RST), .DEAD_RST(DEAD_RST), .DUTY_RST(DUTY_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .run(run), .load(load),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lim_act(lim_act), .dead_q(dead_q), .dead_nx(dead_nx),
    .duty_act(duty_act)
  );

  cpwm3_carrier #(.W(W)) u_car (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .lim(lim_act), .dead_ld(dead_nx), .dead(dead_q),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .up(up), .evt(evt)
  );

  generate
    for (genvar g = 0; g < NPH; g++) begin : g_ph
      cpwm3_phase #(.W(W)) u_ph (
        .clk(clk), .rst(rst), .run(run),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .duty(duty_act[g]),
        .out_p(out_p[g]), .out_n(out_n[g])
      );
    end
  endgenerate
endmodule

// File: rtl/cpwm3_chk.sv
module cpwm3_chk #(
  parameter int W   = 16,
  parameter int NPH = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  run,
  input logic                  tick,
  input logic                  evt,
  input logic [W-1:0]          cnt_a,
  input logic [W-1:0]          cnt_b,
  input logic [W-1:0]          dead_q,
  input logic [NPH-1:0][W-1:0] duty_act,
  input logic [NPH-1:0]        out_p,
  input logic [NPH-1:0]        out_n
);
  // R5
  pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (out_p & out_n) == '0);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (out_p == '0 && out_n == '0));

  // R3
  offset_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (W'(cnt_a - cnt_b) == dead_q));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> ($stable(cnt_a) && $stable(cnt_b)));

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !evt) |=> $stable(duty_act));
endmodule

bind cpwm3_top cpwm3_chk #(.W(W), .NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .run(run), .tick(tick), .evt(evt),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .dead_q(dead_q), .duty_act(duty_act),
  .out_p(out_p), .out_n(out_n)
);

// File: tb/sim_cpwm3_top.sv
module sim_cpwm3_top;
  localparam int PRE = 4;
  localparam int NV  = 4;
  // {lim, dead, duty0, duty1, duty2}
  localparam logic [79:0] VEC [NV] = '{
    {16'd60, 16'd4, 16'd20, 16'd30, 16'd40},
    {16'd60, 16'd4, 16'd0,  16'd61, 16'd60},
    {16'd40, 16'd8, 16'd1,  16'd10, 16'd31},
    {16'd30, 16'd2, 16'd28, 16'd29, 16'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  out_p, out_n;

  int ntest = 0;
  int nfail = 0;
  int hp [3];
  int hn [3];
  int ovl;

  always #5 clk = ~clk;

  cpwm3_top u0 (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .out_p(out_p), .out_n(out_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // on-time in clocks per carrier, from the counter rule of R3/R4
  function automatic int exp_hi(int lim, int dead, int d, bit pos);
    int n = 0;
    for (int v = dead; v < lim; v++)  if (pos ? (v - dead >= d) : (v < d)) n++;
    for (int v = lim; v > dead; v--)  if (pos ? (v - dead >= d) : (v < d)) n++;
    return n * PRE;
  endfunction

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input int e, input bit start);
    run = 1'b0;
    wr(0, int'(VEC[e][79:64]));
    wr(1, int'(VEC[e][63:48]));
    wr(2, int'(VEC[e][47:32]));
    wr(3, int'(VEC[e][31:16]));
    wr(4, int'(VEC[e][15:0]));
    repeat (2) @(negedge clk);
    run = start;
  endtask

  task automatic measure(input int len);
    for (int i = 0; i < 3; i++) begin hp[i] = 0; hn[i] = 0; end
    ovl = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        hp[i] += int'(out_p[i]);
        hn[i] += int'(out_n[i]);
        if (out_p[i] && out_n[i]) ovl++;
      end
    end
  endtask

  // waits for a level on phase 0, counting negedges
  task automatic wait_lvl(input bit pos, input bit lvl, output int cnt);
    cnt = 0;
    while (cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if ((pos ? out_p[0] : out_n[0]) == lvl) return;
    end
    ntest++; nfail++;
    $display("FAIL R3 timeout: actual %0d expected level %0d", cnt, lvl);
  endtask

  // from n0 falling to p0 rising, in clocks
  task automatic gap_np(output int c);
    int d;
    wait_lvl(1'b0, 1'b1, d);
    wait_lvl(1'b0, 1'b0, d);
    wait_lvl(1'b1, 1'b1, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    ntest++; nfail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    int c, hi, lim, dead, per;
    repeat (4) @(negedge clk);
    // R1: outputs off in reset
    chk("R1 reset p", int'(out_p), 0);
    chk("R1 reset n", int'(out_n), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 stopped p", int'(out_p), 0);

    // R11: reset settings, one full default carrier
    run = 1'b1;
    repeat (16008) @(negedge clk);
    measure(16000);
    chk("R11 default p0", hp[0], exp_hi(2040, 40, 1020, 1'b1));
    chk("R11 default n0", hn[0], exp_hi(2040, 40, 1020, 1'b0));
    // R1: stop forces outputs low one clock later
    run = 1'b0;
    @(negedge clk);
    chk("R1 stop", int'({out_p, out_n}), 0);

    // table walk: R4 counts, R9 saturation, R5 exclusion
    for (int e = 0; e < NV; e++) begin
      apply(e, 1'b1);
      lim  = int'(VEC[e][79:64]);
      dead = int'(VEC[e][63:48]);
      per  = 2 * (lim - dead) * PRE;
      repeat (per + 8) @(negedge clk);
      measure(per);
      for (int i = 0; i < 3; i++) begin
        int d;
        d = int'(VEC[e][47 - 16*i -: 16]);
        chk((e == 1) ? "R9 p" : "R4 p", hp[i], exp_hi(lim, dead, d, 1'b1));
        chk((e == 1) ? "R9 n" : "R4 n", hn[i], exp_hi(lim, dead, d, 1'b0));
      end
      chk("R5 overlap", ovl, 0);
    end

    // R3 carrier period, R2 prescaled steps
    apply(0, 1'b1);
    repeat (500) @(negedge clk);
    wait_lvl(1'b1, 1'b0, c);
    wait_lvl(1'b1, 1'b1, c);
    wait_lvl(1'b1, 1'b0, c);
    wait_lvl(1'b1, 1'b1, hi);
    chk("R3 period", c + hi, 448);

    // R6: duty written during up-count takes effect at the crest
    gap_np(c);
    wait_lvl(1'b0, 1'b0, c);
    wait_lvl(1'b0, 1'b1, c);
    wait_lvl(1'b0, 1'b0, c);
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 16'd40;
    c = 0;
    while (c < 2000) begin
      @(negedge clk);
      c++;
      wr_en = 1'b0;
      if (out_p[0]) break;
    end
    chk("R2 R5 gap n->p", c, 16);
    hi = 1;
    while (hi < 2000) begin
      @(negedge clk);
      if (out_p[0]) hi++; else break;
    end
    chk("R6 pulse across crest", hi, 212);
    wait_lvl(1'b0, 1'b1, c);
    chk("R5 gap p->n", c, 16);
    repeat (8) @(negedge clk);
    measure(448);
    chk("R6 new duty p0", hp[0], exp_hi(60, 4, 40, 1'b1));

    // R7: limit written during up-count waits for the crest
    apply(0, 1'b1);
    repeat (500) @(negedge clk);
    wait_lvl(1'b0, 1'b1, c);
    wait_lvl(1'b0, 1'b0, c);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'd80;
    c = 0;
    while (c < 2000) begin
      @(negedge clk);
      c++;
      wr_en = 1'b0;
      if (out_p[0]) break;
    end
    hi = 1;
    while (hi < 2000) begin
      @(negedge clk);
      if (out_p[0]) hi++; else break;
    end
    chk("R7 old limit pulse", hi, 292);
    wait_lvl(1'b1, 1'b1, c);
    wait_lvl(1'b1, 1'b0, c);
    wait_lvl(1'b1, 1'b1, hi);
    chk("R7 new period", c + hi, 608);

    // R8: dead-time write while running is dropped
    apply(0, 1'b1);
    repeat (500) @(negedge clk);
    wr(1, 10);
    gap_np(c);
    chk("R8 gap running", c, 16);
    run = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    repeat (500) @(negedge clk);
    gap_np(c);
    chk("R8 gap restart", c, 16);

    // R10: unused select codes change nothing
    apply(0, 1'b0);
    wr(5, 0);
    wr(6, 0);
    wr(7, 0);
    run = 1'b1;
    repeat (456) @(negedge clk);
    measure(448);
    for (int i = 0; i < 3; i++)
      chk("R10 p", hp[i], exp_hi(60, 4, int'(VEC[0][47 - 16*i -: 16]), 1'b1));

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule